// File: doc/BRIEF.md
# Serial display command decoder

This block accepts 8-bit command words over a three-wire serial link: a data line, a serial clock and an active-low load enable. Bits are collected while the load enable is low. When the load enable is released, the collected word is decoded. Its top three bits select the target for the low five bits:
- one row of a 140-bit dot memory,
- the character pointer,
- the control word,
- or a clear of the dot memory.

The dot memory holds 4 characters of 7 rows by 5 columns. A character is written as one address command followed by up to seven column-data commands. An internal row pointer steps through rows 0 to 6 on each column-data command.

A separate combinational read port lets a display scan engine fetch any row. The serial inputs are asynchronous to the system clock. They are synchronised and edge-detected inside the block, which assumes the system clock runs at least four times faster than the serial clock.

Top module: `serial_disp_decoder`

## Requirements
- R1: A serial bit is captured only on a rising edge of `sclk_i` seen while `load_ni` is low. Serial clock edges while `load_ni` is high are not counted.
- R2: Bits arrive least significant first. A word is decoded only when `load_ni` rises after exactly eight captured bits. Its opcode is bits 7..5. A word with fewer or more than eight bits is dropped with no effect.
- R3: Opcode 000 writes bits 4..0 into the row at the row pointer of the current character. Read data bit 4 is column 0 (the leftmost dot) and bit 0 is column 4.
- R4: The row pointer returns to row 0 on every accepted address command and steps by one after each column-data command. A column-data command after row 6 has been written changes no memory.
- R5: Opcode 101 sets the character pointer from bits 2..0 when that value is 0 to 3. Values 4 to 7 leave the pointer and the row pointer unchanged. Bits 4..3 are ignored.
- R6: Opcode 110 clears all dot memory and sets the character pointer and row pointer to 0. The control word is left as it was.
- R7: Opcode 111 loads bits 4..0 into the control word.
- R8: Opcodes 001, 010, 011 and 100 change no state.
- R9: Asserting `rst_ni` low at once clears the dot memory, the character pointer, the row pointer, the serial word and the control word. A control word of 0 means full brightness.
- R10: `rd_cols_o` shows the stored row for `rd_char_i` and `rd_row_i` in the same cycle, and reads 0 when `rd_row_i` is 7.
- R11: A decoded command takes effect on the third rising edge of `clk_i`, counting the first edge that samples `load_ni` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, least significant bit first |
| load_ni | input | 1 | Load enable, low while bits are shifted; the rising edge decodes |
| rd_char_i | input | 2 | Read port character select |
| rd_row_i | input | 3 | Read port row select |
| rd_cols_o | output | 5 | Read port row data, bit 4 = column 0 |
| char_addr_o | output | 2 | Current character pointer |
| ctrl_word_o | output | 5 | Current control word |

## Verification
The following rules are checked on every cycle:
- The character pointer and the control word change only in the cycle after a decoded command with the matching opcode.
- The bit counter only advances while the synchronised load enable is low.
- The row pointer restarts after an address command and steps after each column write.
- A clear keeps the control word.
- Row 7 always reads as blank.

Only the bench scenarios can show the rest:
- that a word arriving least significant bit first is assembled and routed correctly,
- that short, long and load-high clock sequences are dropped,
- that writes past row 6 and to unused opcodes leave memory intact,
- that the whole memory and the control word follow a behavioural model cycle by cycle, including the decode latency.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int WORD_W = 8;
  localparam int CNT_W  = 4;
  localparam int CTRL_W = 5;

  typedef enum logic [2:0] {
    OP_COLS  = 3'b000,
    OP_ADDR  = 3'b101,
    OP_CLEAR = 3'b110,
    OP_CTRL  = 3'b111
  } opcode_e;
endpackage

// File: rtl/sdd_sync.sv
module sdd_sync #(
  parameter int                WIDTH   = 1,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdd_rx.sv
module sdd_rx
  import sdd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              sdata_s_i,
  input  logic              load_s_i,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic              sclk_q, load_q;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sclk_rise, load_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign load_rise = load_s_i & ~load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      load_q  <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      load_q <= load_s_i;
      if (load_rise) begin
        cnt_q <= '0;
      end else if (sclk_rise && !load_s_i) begin
        shift_q <= {sdata_s_i, shift_q[WORD_W-1:1]};
        // saturate so an overlong word never wraps back to a valid count
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cmd_valid_o = load_rise && (cnt_q == CNT_FULL);
  assign cmd_o       = shift_q;
  assign bit_cnt_o   = cnt_q;
endmodule

// File: rtl/sdd_dot_ram.sv
module sdd_dot_ram #(
  parameter int N_CHARS = 4,
  parameter int N_ROWS  = 7,
  parameter int N_COLS  = 5,
  parameter int CHAR_W  = 2,
  parameter int ROW_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              clr_i,
  input  logic [CHAR_W-1:0] wchar_i,
  input  logic [ROW_W-1:0]  wrow_i,
  input  logic [N_COLS-1:0] wdata_i,
  input  logic [CHAR_W-1:0] rchar_i,
  input  logic [ROW_W-1:0]  rrow_i,
  output logic [N_COLS-1:0] rdata_o
);
  localparam int N_CELLS = N_CHARS * N_ROWS;

  logic [N_CELLS-1:0][N_COLS-1:0] mem_flat;

  for (genvar c = 0; c < N_CHARS; c++) begin : g_char
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      logic [N_COLS-1:0] cell_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)     cell_q <= '0;
        else if (clr_i)  cell_q <= '0;
        else if (we_i && wchar_i == CHAR_W'(c) && wrow_i == ROW_W'(r))
                         cell_q <= wdata_i;
      assign mem_flat[c*N_ROWS+r] = cell_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CHARS; c++)
      for (int r = 0; r < N_ROWS; r++)
        if (rchar_i == CHAR_W'(c) && rrow_i == ROW_W'(r))
          rdata_o = mem_flat[c*N_ROWS+r];
  end
endmodule

// File: rtl/serial_disp_decoder.sv
module serial_disp_decoder
  import sdd_pkg::*;
#(
  parameter int N_CHARS     = 4,
  parameter int N_ROWS      = 7,
  parameter int N_COLS      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int CHAR_W     = $clog2(N_CHARS),
  localparam int ROW_W      = $clog2(N_ROWS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              load_ni,
  input  logic [CHAR_W-1:0] rd_char_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  output logic [N_COLS-1:0] rd_cols_o,
  output logic [CHAR_W-1:0] char_addr_o,
  output logic [CTRL_W-1:0] ctrl_word_o
);
  localparam logic [ROW_W-1:0] ROW_END = ROW_W'(N_ROWS);

  logic              load_s, sclk_s, sdata_s;
  logic              cmd_valid;
  logic [WORD_W-1:0] cmd;
  logic [CNT_W-1:0]  bit_cnt;
  opcode_e           op;
  logic              addr_ok;
  logic [ROW_W-1:0]  row_ptr;
  logic [CHAR_W-1:0] char_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ram_we, ram_clr;

  sdd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({load_ni, sclk_i, sdata_i}),
    .q_o   ({load_s, sclk_s, sdata_s})
  );

  sdd_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .sdata_s_i  (sdata_s),
    .load_s_i   (load_s),
    .cmd_valid_o(cmd_valid),
    .cmd_o      (cmd),
    .bit_cnt_o  (bit_cnt)
  );

  assign op      = opcode_e'(cmd[7:5]);
  assign addr_ok = {29'd0, cmd[2:0]} < 32'(N_CHARS);
  assign ram_we  = cmd_valid && (op == OP_COLS) && (row_ptr < ROW_END);
  assign ram_clr = cmd_valid && (op == OP_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q  <= '0;
      row_ptr <= '0;
      ctrl_q  <= '0;
    end else if (cmd_valid) begin
      case (op)
        OP_COLS:  if (row_ptr < ROW_END) row_ptr <= row_ptr + ROW_W'(1);
        OP_ADDR:  if (addr_ok) begin
                    char_q  <= cmd[CHAR_W-1:0];
                    row_ptr <= '0;
                  end
        OP_CLEAR: begin
                    char_q  <= '0;
                    row_ptr <= '0;
                  end
        OP_CTRL:  ctrl_q <= cmd[CTRL_W-1:0];
        default:  ;
      endcase
    end
  end

  sdd_dot_ram #(
    .N_CHARS(N_CHARS), .N_ROWS(N_ROWS), .N_COLS(N_COLS),
    .CHAR_W (CHAR_W),  .ROW_W (ROW_W)
  ) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .clr_i  (ram_clr),
    .wchar_i(char_q),
    .wrow_i (row_ptr),
    .wdata_i(cmd[N_COLS-1:0]),
    .rchar_i(rd_char_i),
    .rrow_i (rd_row_i),
    .rdata_o(rd_cols_o)
  );

  assign char_addr_o = char_q;
  assign ctrl_word_o = ctrl_q;
endmodule

// File: rtl/sdd_checker.sv
module sdd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_s,
  input logic       cmd_valid,
  input logic [7:0] cmd,
  input logic [3:0] bit_cnt,
  input logic [2:0] row_ptr,
  input logic [1:0] char_addr_o,
  input logic [4:0] ctrl_word_o,
  input logic [2:0] rd_row_i,
  input logic [4:0] rd_cols_o
);
  AST_CNT_LOAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt != 4'd0 && !$stable(bit_cnt)) |-> !$past(load_s)); // R1

  AST_ADDR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(char_addr_o) |-> ($past(cmd_valid) &&
      ($past(cmd[7:5]) == 3'b101 || $past(cmd[7:5]) == 3'b110))); // R5

  AST_CTRL_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_word_o) |-> ($past(cmd_valid) && $past(cmd[7:5]) == 3'b111)); // R7

  AST_CLEAR_KEEPS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && cmd[7:5] == 3'b110) |=>
      (char_addr_o == 2'd0 && row_ptr == 3'd0 && $stable(ctrl_word_o))); // R6

  AST_ROW_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && cmd[7:5] == 3'b101 && !cmd[2]) |=> row_ptr == 3'd0); // R4

  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && cmd[7:5] == 3'b000 && row_ptr < 3'd7) |=>
      row_ptr == $past(row_ptr) + 3'd1); // R4

  AST_ROW7_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_row_i == 3'd7 |-> rd_cols_o == 5'd0); // R10
endmodule

bind serial_disp_decoder sdd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_s     (load_s),
  .cmd_valid  (cmd_valid),
  .cmd        (cmd),
  .bit_cnt    (bit_cnt),
  .row_ptr    (row_ptr),
  .char_addr_o(char_addr_o),
  .ctrl_word_o(ctrl_word_o),
  .rd_row_i   (rd_row_i),
  .rd_cols_o  (rd_cols_o)
);

// File: tb/serial_disp_decoder_tb.sv
module serial_disp_decoder_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b0;
  logic       sdata_i = 1'b0;
  logic       load_ni = 1'b1;
  logic [1:0] rd_char_i = 2'd0;
  logic [2:0] rd_row_i = 3'd0;
  logic [4:0] rd_cols_o;
  logic [1:0] char_addr_o;
  logic [4:0] ctrl_word_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  scan_en = 1'b0;
  bit  done = 1'b0;

  always #10 clk_i = ~clk_i;

  serial_disp_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .load_ni(load_ni), .rd_char_i(rd_char_i), .rd_row_i(rd_row_i),
    .rd_cols_o(rd_cols_o), .char_addr_o(char_addr_o), .ctrl_word_o(ctrl_word_o)
  );

  // behavioural reference model
  int m_ram [4][7];
  int m_addr, m_ctrl, m_row, m_cnt;
  bit [7:0] m_word;
  bit h_ld [4];
  bit h_ck [4];
  bit h_dt [4];

  task automatic m_reset();
    for (int c = 0; c < 4; c++) for (int r = 0; r < 7; r++) m_ram[c][r] = 0;
    m_addr = 0; m_ctrl = 0; m_row = 0; m_cnt = 0; m_word = '0;
    for (int i = 0; i < 4; i++) begin h_ld[i] = 1; h_ck[i] = 0; h_dt[i] = 0; end
  endtask

  task automatic m_exec(input bit [7:0] w);
    int opc;
    opc = int'(w[7:5]);
    if (opc == 0) begin
      if (m_row < 7) begin m_ram[m_addr][m_row] = int'(w[4:0]); m_row++; end
    end else if (opc == 5) begin
      if (int'(w[2:0]) < 4) begin m_addr = int'(w[2:0]); m_row = 0; end
    end else if (opc == 6) begin
      for (int c = 0; c < 4; c++) for (int r = 0; r < 7; r++) m_ram[c][r] = 0;
      m_addr = 0; m_row = 0;
    end else if (opc == 7) begin
      m_ctrl = int'(w[4:0]);
    end
  endtask

  initial m_reset();

  always @(posedge clk_i) begin
    if (!rst_ni) m_reset();
    else begin
      for (int i = 3; i > 0; i--) begin
        h_ld[i] = h_ld[i-1]; h_ck[i] = h_ck[i-1]; h_dt[i] = h_dt[i-1];
      end
      h_ld[0] = load_ni; h_ck[0] = sclk_i; h_dt[0] = sdata_i;
      if (h_ld[2] && !h_ld[3]) begin
        if (m_cnt == 8) m_exec(m_word);
        m_cnt = 0;
      end else if (h_ck[2] && !h_ck[3] && !h_ld[2]) begin
        if (m_cnt < 8) m_word[m_cnt] = h_dt[2];
        m_cnt++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R11 latency included)
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R11 char_addr", int'(char_addr_o), m_addr);
      chk("R11 ctrl_word", int'(ctrl_word_o), m_ctrl);
      chk("R11 rd_cols", int'(rd_cols_o), (rd_row_i < 3'd7) ? m_ram[rd_char_i][rd_row_i] : 0);
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  task automatic tick();
    @(posedge clk_i); #2;
    if (scan_en) begin
      rd_row_i = rd_row_i + 3'd1;
      if (rd_row_i == 3'd0) rd_char_i = rd_char_i + 2'd1;
    end
  endtask

  task automatic send(input bit [15:0] w, input int nbits);
    load_ni = 1'b0;
    repeat (4) tick();
    for (int i = 0; i < nbits; i++) begin
      sdata_i = w[i];
      repeat (4) tick();
      sclk_i = 1'b1;
      repeat (4) tick();
      sclk_i = 1'b0;
    end
    repeat (4) tick();
    load_ni = 1'b1;
    repeat (8) tick();
  endtask

  task automatic expect_row(input int c, input int r, input int exp, input string tag);
    bit keep;
    keep = scan_en; scan_en = 1'b0;
    @(posedge clk_i); #2;
    rd_char_i = 2'(c); rd_row_i = 3'(r);
    @(negedge clk_i);
    chk(tag, int'(rd_cols_o), exp);
    scan_en = keep;
  endtask

  task automatic expect_regs(input int addr, input int ctrl, input string tag);
    @(negedge clk_i);
    chk({tag, " addr"}, int'(char_addr_o), addr);
    chk({tag, " ctrl"}, int'(ctrl_word_o), ctrl);
  endtask

  initial begin
    repeat (4) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    // R9 reset state
    expect_regs(0, 0, "R9 reset");
    for (int c = 0; c < 4; c++) for (int r = 0; r < 7; r++)
      expect_row(c, r, 0, "R9 reset ram");
    scan_en = 1'b1;

    send(16'hE3, 8);  expect_regs(0, 3, "R7 R2 ctrl load");
    send(16'hA2, 8);  expect_regs(2, 3, "R5 addr load");
    send(16'h10, 8); send(16'h01, 8); send(16'h0A, 8); send(16'h15, 8);
    send(16'h1F, 8); send(16'h03, 8); send(16'h18, 8);
    expect_row(2, 0, 5'h10, "R3 column0 is bit4");
    expect_row(2, 1, 5'h01, "R3 column4 is bit0");
    expect_row(2, 3, 5'h15, "R4 row step");
    expect_row(2, 6, 5'h18, "R4 last row");
    send(16'h07, 8);
    expect_row(2, 6, 5'h18, "R4 write past row6 ignored");
    expect_row(3, 0, 0, "R4 write past row6 no spill");
    send(16'hA5, 8);  expect_regs(2, 3, "R5 addr 5 ignored");
    send(16'hA1, 8);  expect_regs(1, 3, "R5 addr 1");
    send(16'h0C, 8);  expect_row(1, 0, 5'h0C, "R4 row restart");

    send(16'h00E7, 5); expect_regs(1, 3, "R2 short word dropped");
    send(16'h00E7, 9); expect_regs(1, 3, "R2 long word dropped");

    // R1: clock edges with load high must not count
    sdata_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      repeat (4) tick(); sclk_i = 1'b1; repeat (4) tick(); sclk_i = 1'b0;
    end
    repeat (4) tick();
    send(16'h001F, 5); expect_regs(1, 3, "R1 load high clocks ignored");

    send(16'h3F, 8); send(16'h5F, 8); send(16'h7F, 8); send(16'h9F, 8);
    expect_regs(1, 3, "R8 unused opcodes");
    expect_row(1, 1, 0, "R8 no ram write");
    send(16'h11, 8);
    expect_row(1, 1, 5'h11, "R8 row pointer unmoved");
    expect_row(1, 2, 0, "R8 next row clean");

    send(16'hC0, 8);  expect_regs(0, 3, "R6 clear keeps ctrl");
    expect_row(2, 0, 0, "R6 ram cleared");
    expect_row(1, 1, 0, "R6 ram cleared");
    send(16'h05, 8);  expect_row(0, 0, 5'h05, "R6 row restart");
    expect_row(0, 7, 0, "R10 row7 blank");

    send(16'hE6, 8);  expect_regs(0, 6, "R7 ctrl reload");
    @(posedge clk_i); #2 rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R9 async reset addr", int'(char_addr_o), 0);
    chk("R9 async reset ctrl", int'(ctrl_word_o), 0);
    chk("R9 async reset ram", int'(rd_cols_o), 0);
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    expect_row(0, 0, 0, "R9 ram after reset");
    send(16'hE5, 8);  expect_regs(0, 5, "R9 R7 after reset");
    repeat (10) tick();
    summary();
  end
endmodule